// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block keeps the control fields of a multi-mode clock generator. Firmware reads back the status fields while it steps the generator between modes. The block decodes five things: the output source select, the loop-type select (PLL or FLL), the low-power bypass bit, the reference-divider code and the VCO multiplier code. From these it works out which external-reference mode is active and derives the effective divide and multiply settings.

The phase-locked loop is a behavioural model: a lock timer counts reference cycles once the loop is enabled. Clock switching is modelled as a one-hot source select. Status lags the control writes by a synchronising delay, so firmware has to poll it. After each write that changes the mode, firmware waits for the loop-active bit, then the lock bit, then the clock-status field.

The bus clock runs at half the main output clock. It is brought out as a clock enable that is high on every second cycle.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: After reset the register fields read 0 at addresses 0 to 3, `mode` is 0, the PLL is neither enabled nor locked, `src_onehot` is 4'b0001, and both `ref_div_exp` and `vco_mult` are 0.
- R2: The register map is as follows.
  - Address 0 holds the source select in bits 7:6 and the reference-divider code in bits 5:3.
  - Address 1 holds the low-power bit in bit 3.
  - Address 2 holds the loop select in bit 6 (1 = PLL), the /32 bit in bit 4 and the multiplier code in bits 3:0.
  - Address 3 is the read-only status word. Bit 6 is lock, bit 5 is loop-active and bits 3:2 are the clock status.
  - All other bits and addresses read 0. Writes to address 3 or to unmapped addresses change nothing.
- R3: `mode` reports the active mode.
  - 1 (bypassed low-power external) when the source select is 2'b10 and the low-power bit is set.
  - 2 (PLL bypassed external) when the source select is 2'b10, the low-power bit is clear and the PLL is selected.
  - 3 (PLL engaged external) when the source select is 2'b00 and the PLL is selected.
  - 0 otherwise.
- R4: `pll_enabled` is high when the PLL is selected and mode 1 is not active. While mode 1 holds, writes to the loop select and multiplier only prepare values, and lock stays low.
- R5: `pll_locked` (status bit 6) rises exactly LOCK_CYCLES clock edges after the edge at which the PLL becomes enabled.
- R6: Lock drops from the edge at which the PLL is disabled, or at which a write changes the divider or the multiplier code. Counting then restarts from zero.
- R7: Status bit 5 (loop-active) equals `pll_enabled` delayed by SYNC_STAGES cycles.
- R8: The clock status takes its new value SYNC_STAGES cycles after the request, and only while the requested source is valid. Otherwise it holds its last value.
  - Select 2'b00 requests code 2'b11 when the PLL is selected, and that request is valid only while locked. With the FLL selected it requests code 2'b00.
  - Select 2'b01 requests code 2'b01.
  - Select 2'b10 requests code 2'b10.
  - Select 2'b11 is never valid.
- R9: `src_onehot` has exactly one bit set, at the index given by the clock-status code.
- R10: `ref_div_exp` is log2 of the reference divide. With the PLL selected it equals the divider code, and the /32 bit is ignored. With the FLL selected it equals the code plus 5 when the /32 bit is set, so code 3 gives 8 (PLL) or 256 (FLL).
- R11: `vco_mult` is 4 times the multiplier code, so code 4'b1000 gives 32.
- R12: `bus_ce` is low in the first cycle after reset and then alternates every cycle, marking the bus clock as the main clock divided by 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock, also used as the reference-cycle tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| mode | output | 2 | Active mode code |
| pll_enabled | output | 1 | PLL model is running |
| pll_locked | output | 1 | PLL lock indication |
| src_onehot | output | 4 | One-hot source select driving the main clock output |
| ref_div_exp | output | 4 | log2 of the effective reference divide |
| vco_mult | output | 6 | Effective VCO multiply factor |
| bus_ce | output | 1 | Bus clock enable, high every second cycle |

## Verification
Each state element becomes visible at the ports after a fixed and short delay. A lock counter that is off by one moves the rising edge of `pll_locked` by one cycle from the expected LOCK_CYCLES point. A stale status pipeline stage shows up as a clock-status or loop-active bit that is wrong in status reads exactly SYNC_STAGES cycles after the write that caused it. A clock-status register that fails to hold on an invalid request shows as an early 2'b11 during the relock window. Mode and divide decode errors appear in the same cycle the control field changes.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;

   // register addresses (status must stay last of the mapped ones)
   localparam logic [2:0] ADR_SRC  = 3'd0;
   localparam logic [2:0] ADR_PWR  = 3'd1;
   localparam logic [2:0] ADR_LOOP = 3'd2;
   localparam logic [2:0] ADR_STAT = 3'd3;

   // output source select codes
   localparam logic [1:0] SEL_LOOP = 2'b00;
   localparam logic [1:0] SEL_INT  = 2'b01;
   localparam logic [1:0] SEL_EXT  = 2'b10;

   // clock status codes (index into the one-hot select)
   localparam logic [1:0] ST_FLL = 2'b00;
   localparam logic [1:0] ST_INT = 2'b01;
   localparam logic [1:0] ST_EXT = 2'b10;
   localparam logic [1:0] ST_PLL = 2'b11;

   localparam int NUM_SRC = 4;
   localparam int RDIV_W  = 3;
   localparam int VMUL_W  = 4;
   localparam int FLL_EXTRA_EXP = 5;

   typedef enum logic [1:0] {
      MD_OTHER   = 2'd0,
      MD_BYP_LP  = 2'd1,
      MD_BYP_PLL = 2'd2,
      MD_PLL_ENG = 2'd3
   } mode_t;

   typedef struct packed {
      logic [1:0]        src_sel;
      logic [RDIV_W-1:0] rdiv;
      logic              lowpwr;
      logic              pll_sel;
      logic              div32;
      logic [VMUL_W-1:0] vmul;
   } cfg_t;

endpackage

// File: rtl/clkgen_cfg_regs.sv
`timescale 1ns/1ps
module clkgen_cfg_regs
   import clkgen_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] stat_word,
   output cfg_t              cfg,
   output logic              cfg_change,
   output logic [DATA_W-1:0] rdata
);

   if (DATA_W != 8) begin : g_bad_data_w
      $error("clkgen_cfg_regs: field layout needs an 8-bit data path");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("clkgen_cfg_regs: address must reach four registers");
   end

   logic hit_src;
   logic hit_pwr;
   logic hit_loop;

   assign hit_src  = wr_en && (addr == ADDR_W'(ADR_SRC));
   assign hit_pwr  = wr_en && (addr == ADDR_W'(ADR_PWR));
   assign hit_loop = wr_en && (addr == ADDR_W'(ADR_LOOP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else begin
         if (hit_src) begin
            cfg.src_sel <= wdata[7:6];
            cfg.rdiv    <= wdata[5:3];
         end
         if (hit_pwr) begin
            cfg.lowpwr  <= wdata[3];
         end
         if (hit_loop) begin
            cfg.pll_sel <= wdata[6];
            cfg.div32   <= wdata[4];
            cfg.vmul    <= wdata[3:0];
         end
      end
   end

   // a write that alters the loop's divide or multiply restarts lock
   assign cfg_change = (hit_src  && (wdata[5:3] != cfg.rdiv)) ||
                       (hit_loop && (wdata[3:0] != cfg.vmul));

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADR_SRC)) begin
         rdata = {cfg.src_sel, cfg.rdiv, 3'b000};
      end else if (addr == ADDR_W'(ADR_PWR)) begin
         rdata = {4'b0000, cfg.lowpwr, 3'b000};
      end else if (addr == ADDR_W'(ADR_LOOP)) begin
         rdata = {1'b0, cfg.pll_sel, 1'b0, cfg.div32, cfg.vmul};
      end else if (addr == ADDR_W'(ADR_STAT)) begin
         rdata = stat_word;
      end
   end

endmodule

// File: rtl/clkgen_lock_timer.sv
`timescale 1ns/1ps
module clkgen_lock_timer #(
   parameter int LOCK_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pll_en,
   input  logic restart,
   output logic locked
);

   localparam int CNT_W = (LOCK_CYCLES < 2) ? 1 : $clog2(LOCK_CYCLES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

   if (LOCK_CYCLES < 1) begin : g_bad_lock
      $error("clkgen_lock_timer: LOCK_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         lock_q <= 1'b0;
      end else if (!pll_en || restart) begin
         cnt    <= '0;
         lock_q <= 1'b0;
      end else if (cnt == LAST) begin
         lock_q <= 1'b1;
      end else begin
         cnt    <= cnt + 1'b1;
      end
   end

   // gate with the enable so a disable write drops lock without waiting
   assign locked = lock_q & pll_en;

endmodule

// File: rtl/clkgen_hold_sync.sv
`timescale 1ns/1ps
module clkgen_hold_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   input  logic         d_ok,
   output logic [W-1:0] q
);

   localparam int NSTG = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("clkgen_hold_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("clkgen_hold_sync: W must be at least 1");
   end

   // each stage carries {valid, value}; the last flop only loads valid values
   logic [W:0] stg [NSTG];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSTG; i++) stg[i] <= '0;
         q <= '0;
      end else begin
         stg[0] <= {d_ok, d};
         for (int i = 1; i < NSTG; i++) stg[i] <= stg[i-1];
         if (stg[NSTG-1][W]) q <= stg[NSTG-1][W-1:0];
      end
   end

endmodule

// File: rtl/clkgen_mode_ctrl.sv
`timescale 1ns/1ps
module clkgen_mode_ctrl
   import clkgen_pkg::*;
#(
   parameter int LOCK_CYCLES = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic [1:0] mode,
   output logic       pll_enabled,
   output logic       pll_locked,
   output logic [3:0] src_onehot,
   output logic [3:0] ref_div_exp,
   output logic [5:0] vco_mult,
   output logic       bus_ce
);

   localparam int EXP_W  = 4;
   localparam int MULT_W = VMUL_W + 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clkgen_mode_ctrl: SYNC_STAGES must be at least 2");
   end

   cfg_t       cfg;
   logic       cfg_change;
   logic [7:0] stat_word;
   mode_t      mode_d;
   logic       pll_st;
   logic [1:0] src_st;
   logic [1:0] req_code;
   logic       req_ok;

   clkgen_cfg_regs #(.ADDR_W(3), .DATA_W(8)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .addr       (addr),
      .wdata      (wdata),
      .stat_word  (stat_word),
      .cfg        (cfg),
      .cfg_change (cfg_change),
      .rdata      (rdata)
   );

   // mode decode, bypass with low power wins over everything external
   always_comb begin
      mode_d = MD_OTHER;
      if (cfg.src_sel == SEL_EXT && cfg.lowpwr) begin
         mode_d = MD_BYP_LP;
      end else if (cfg.src_sel == SEL_EXT && cfg.pll_sel) begin
         mode_d = MD_BYP_PLL;
      end else if (cfg.src_sel == SEL_LOOP && cfg.pll_sel) begin
         mode_d = MD_PLL_ENG;
      end
   end

   assign mode        = mode_d;
   assign pll_enabled = cfg.pll_sel && (mode_d != MD_BYP_LP);

   clkgen_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .pll_en  (pll_enabled),
      .restart (cfg_change),
      .locked  (pll_locked)
   );

   // requested output source and whether it may be switched to now
   always_comb begin
      req_code = ST_FLL;
      req_ok   = 1'b0;
      case (cfg.src_sel)
         SEL_LOOP: begin
            req_code = cfg.pll_sel ? ST_PLL : ST_FLL;
            req_ok   = cfg.pll_sel ? pll_locked : 1'b1;
         end
         SEL_INT: begin
            req_code = ST_INT;
            req_ok   = 1'b1;
         end
         SEL_EXT: begin
            req_code = ST_EXT;
            req_ok   = 1'b1;
         end
         default: begin
            req_code = ST_FLL;
            req_ok   = 1'b0;
         end
      endcase
   end

   clkgen_hold_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pll_st (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pll_enabled),
      .d_ok  (1'b1),
      .q     (pll_st)
   );

   clkgen_hold_sync #(.W(2), .STAGES(SYNC_STAGES)) u_src_st (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_code),
      .d_ok  (req_ok),
      .q     (src_st)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_sel
      assign src_onehot[s] = (src_st == 2'(s));
   end

   assign stat_word = {1'b0, pll_locked, pll_st, 1'b0, src_st, 2'b00};

   // reference divide as an exponent; the extra /32 applies to the FLL only
   assign ref_div_exp = cfg.pll_sel ? EXP_W'(cfg.rdiv)
                                    : EXP_W'(cfg.rdiv) + (cfg.div32 ? EXP_W'(FLL_EXTRA_EXP) : '0);
   assign vco_mult    = MULT_W'({cfg.vmul, 2'b00});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_ce <= 1'b0;
      else        bus_ce <= ~bus_ce;
   end

endmodule

// File: rtl/clkgen_mode_ctrl_chk.sv
`timescale 1ns/1ps
module clkgen_mode_ctrl_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode,
   input logic       pll_enabled,
   input logic       pll_locked,
   input logic [3:0] src_onehot,
   input logic [3:0] ref_div_exp,
   input logic [5:0] vco_mult,
   input logic       bus_ce,
   input logic       pll_st,
   input logic [1:0] src_st
);

   logic [1:0] age;
   logic       warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end
   assign warm = (age == 2'd3);

   a_r4_lowpower_keeps_pll_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1) |-> !pll_enabled);

   a_r5_lock_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_locked) |-> $past(pll_enabled));

   a_r6_mult_change_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(vco_mult) |-> !pll_locked);

   a_r9_single_source: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(src_onehot) == 1);

   a_r10_pll_divide_range: assert property (@(posedge clk) disable iff (!rst_n)
      pll_enabled |-> (ref_div_exp <= 4'd7));

   a_r12_bus_ce_alternates: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (bus_ce != $past(bus_ce)));

   if (SYNC_STAGES == 2) begin : g_two_stage
      a_r7_loop_status_lag: assert property (@(posedge clk) disable iff (!rst_n)
         warm |-> (pll_st == $past(pll_enabled, 2)));

      a_r8_pll_status_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
         (warm && $changed(src_st) && src_st == 2'b11) |-> $past(pll_locked, 2));
   end

endmodule

bind clkgen_mode_ctrl clkgen_mode_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mode        (mode),
   .pll_enabled (pll_enabled),
   .pll_locked  (pll_locked),
   .src_onehot  (src_onehot),
   .ref_div_exp (ref_div_exp),
   .vco_mult    (vco_mult),
   .bus_ce      (bus_ce),
   .pll_st      (pll_st),
   .src_st      (src_st)
);

// File: tb/clkgen_mode_ctrl_test.sv
`timescale 1ns/1ps
module clkgen_mode_ctrl_test;

   localparam int LOCK_N = 12;
   localparam int SYNC_N = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = 3'd3;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic [1:0] mode;
   logic       pll_enabled;
   logic       pll_locked;
   logic [3:0] src_onehot;
   logic [3:0] ref_div_exp;
   logic [5:0] vco_mult;
   logic       bus_ce;

   int checks = 0;
   int errors = 0;
   bit run_cmp = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   clkgen_mode_ctrl #(.LOCK_CYCLES(LOCK_N), .SYNC_STAGES(SYNC_N)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .mode(mode), .pll_enabled(pll_enabled), .pll_locked(pll_locked),
      .src_onehot(src_onehot), .ref_div_exp(ref_div_exp), .vco_mult(vco_mult),
      .bus_ce(bus_ce)
   );

   // ---------------- behavioural reference model ----------------
   int m_src, m_rdiv, m_lp, m_psel, m_d32, m_vmul;
   int m_cnt, m_lockq, m_pllst, m_srcst, m_bus;
   int q_en[$];
   int q_req[$];

   function automatic int f_pll_en();
      return (m_psel != 0 && !(m_src == 2 && m_lp != 0)) ? 1 : 0;
   endfunction

   function automatic int f_mode();
      if (m_src == 2 && m_lp != 0) return 1;
      if (m_src == 2 && m_psel != 0) return 2;
      if (m_src == 0 && m_psel != 0) return 3;
      return 0;
   endfunction

   function automatic int f_lock();
      return (m_lockq != 0 && f_pll_en() != 0) ? 1 : 0;
   endfunction

   // request encoded as valid*4 + code
   function automatic int f_req();
      case (m_src)
         0: return (m_psel != 0) ? (f_lock() * 4 + 3) : 4;
         1: return 5;
         2: return 6;
         default: return 0;
      endcase
   endfunction

   function automatic int f_rd(int a);
      case (a)
         0: return m_src * 64 + m_rdiv * 8;
         1: return m_lp * 8;
         2: return m_psel * 64 + m_d32 * 16 + m_vmul;
         3: return f_lock() * 64 + m_pllst * 32 + m_srcst * 4;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      int en_old;
      int req_old;
      int chg;
      int h;
      if (!rst_n) begin
         m_src = 0; m_rdiv = 0; m_lp = 0; m_psel = 0; m_d32 = 0; m_vmul = 0;
         m_cnt = 0; m_lockq = 0; m_pllst = 0; m_srcst = 0; m_bus = 0;
         q_en.delete(); q_req.delete();
         for (int i = 0; i < SYNC_N - 1; i++) begin q_en.push_back(0); q_req.push_back(0); end
      end else begin
         en_old  = f_pll_en();
         req_old = f_req();
         chg = (wr_en && ((addr == 0 && int'(wdata[5:3]) != m_rdiv) ||
                          (addr == 2 && int'(wdata[3:0]) != m_vmul))) ? 1 : 0;
         if (en_old == 0 || chg != 0) begin m_cnt = 0; m_lockq = 0; end
         else if (m_cnt == LOCK_N - 1) m_lockq = 1;
         else m_cnt++;
         q_en.push_back(en_old);
         m_pllst = q_en.pop_front();
         q_req.push_back(req_old);
         h = q_req.pop_front();
         if (h >= 4) m_srcst = h - 4;
         m_bus = 1 - m_bus;
         if (wr_en) begin
            case (addr)
               3'd0: begin m_src = int'(wdata[7:6]); m_rdiv = int'(wdata[5:3]); end
               3'd1: m_lp = int'(wdata[3]);
               3'd2: begin m_psel = int'(wdata[6]); m_d32 = int'(wdata[4]); m_vmul = int'(wdata[3:0]); end
               default: ;
            endcase
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (run_cmp && rst_n) begin
         chk("R3", int'(mode), f_mode());
         chk("R4", int'(pll_enabled), f_pll_en());
         chk("R5", int'(pll_locked), f_lock());
         chk("R9", int'(src_onehot), 1 << m_srcst);
         chk("R10", int'(ref_div_exp), (m_psel != 0) ? m_rdiv : m_rdiv + ((m_d32 != 0) ? 5 : 0));
         chk("R11", int'(vco_mult), m_vmul * 4);
         chk("R12", int'(bus_ce), m_bus);
         if (addr == 3) begin
            chk("R7", int'(rdata[5]), m_pllst);
            chk("R8", int'(rdata[3:2]), m_srcst);
         end
         chk("R2", int'(rdata), f_rd(int'(addr)));
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk); #1;
      wr_en = 1'b1; addr = 3'(a); wdata = 8'(d);
      @(negedge clk); #1;
      wr_en = 1'b0; addr = 3'd3;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic rd_chk(input string tag, input int a, input int exp);
      addr = 3'(a); #1;
      chk(tag, int'(rdata), exp);
      addr = 3'd3;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      bit [15:0] lfsr;
      int a;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1", int'(mode), 0);
      chk("R1", int'(pll_enabled), 0);
      chk("R1", int'(pll_locked), 0);
      chk("R1", int'(src_onehot), 1);
      chk("R1", int'(ref_div_exp), 0);
      chk("R1", int'(vco_mult), 0);
      for (int k = 0; k < 4; k++) rd_chk("R1", k, 0);
      run_cmp = 1;

      // R2: field masks, read-only status, unmapped address
      wr(2, 8'hFF);
      rd_chk("R2", 2, 8'h5F);
      wr(1, 8'hFF);
      rd_chk("R2", 1, 8'h08);
      wr(3, 8'hFF);
      wr(5, 8'hFF);
      rd_chk("R2", 5, 0);
      wr(1, 0);
      wr(2, 0);
      idle(3);
      rd_chk("R2", 3, 0);

      // FLL external with /32: divider code 3 gives 2^8
      wr(0, 8'b10_011_000);
      wr(2, 8'h10);
      chk("R10", int'(ref_div_exp), 8);
      // low-power bypass
      wr(1, 8'h08);
      chk("R3", int'(mode), 1);
      // prepare PLL with x32 while bypassed low-power
      wr(2, 8'h58);
      chk("R10", int'(ref_div_exp), 3);
      chk("R11", int'(vco_mult), 32);
      chk("R4", int'(pll_enabled), 0);
      idle(20);
      chk("R4", int'(pll_locked), 0);
      // clear low power: PLL bypassed external, lock after LOCK_N edges
      wr(1, 0);
      chk("R3", int'(mode), 2);
      idle(LOCK_N - 1);
      chk("R5", int'(pll_locked), 0);
      idle(1);
      chk("R5", int'(pll_locked), 1);
      chk("R7", int'(rdata[5]), 1);
      // multiplier change drops lock and restarts the count
      wr(2, 8'h59);
      chk("R6", int'(pll_locked), 0);
      idle(LOCK_N - 1);
      chk("R6", int'(pll_locked), 0);
      idle(1);
      chk("R6", int'(pll_locked), 1);
      // engage the PLL as main source
      wr(0, 8'b00_011_000);
      chk("R3", int'(mode), 3);
      idle(1);
      chk("R8", int'(rdata[3:2]), 2);
      idle(1);
      chk("R8", int'(rdata[3:2]), 3);
      chk("R9", int'(src_onehot), 8);
      // back to FLL, then PLL again: status waits for relock
      wr(2, 8'h19);
      idle(2);
      chk("R8", int'(rdata[3:2]), 0);
      chk("R7", int'(rdata[5]), 0);
      wr(2, 8'h59);
      idle(LOCK_N + 1);
      chk("R8", int'(rdata[3:2]), 0);
      idle(1);
      chk("R8", int'(rdata[3:2]), 3);
      // internal source, then reserved select holds status
      wr(0, 8'h40);
      idle(2);
      chk("R8", int'(rdata[3:2]), 1);
      wr(0, 8'hC0);
      idle(4);
      chk("R8", int'(rdata[3:2]), 1);
      chk("R9", int'(src_onehot), 2);

      // pseudo-random register traffic checked against the model each cycle
      lfsr = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         a = int'(lfsr[2:0]);
         if (a > 3 && a != 5) a = int'(lfsr[1:0]);
         wr(a, int'(lfsr[15:8]));
         idle(int'(lfsr[7:4]));
      end

      done = 1;
      finish_run();
   end

endmodule